// File: doc/BRIEF.md
# Write-Protect Policy Unit

This block sits beside the serial bus engine of a 256-byte non-volatile array. For each byte that the engine wants to commit, it decides whether the write may go ahead. The decision combines two things. The first is a hardware protect pin, which blocks the whole array. The second is a one-bit software protect flag, which blocks only the lower half. The flag can be set by a command but cannot be cleared by ordinary traffic. Only a special reset command clears it, and that command counts only when a high-voltage condition has been present on the protect pin long enough beforehand. The flag's non-volatile storage is modelled as a register whose power-on value comes from a parameter.

The bus engine delivers single-cycle strobes. One marks that a set-protect command has been received, one marks that a reset-fuse command has begun, and one marks the stop condition that ends a transaction. A pending command takes effect only at the stop strobe. The engine reads two results back from the block. The first, `wr_allowed`, applies to the address presented on `wr_addr`. The second, `prot_ack`, tells the engine whether to acknowledge a protect-register control byte. A write that is refused is still acknowledged on the bus and still runs its full write-cycle time. Both of those duties belong to the engine, which only suppresses the array update when `wr_allowed` is low.

The command tracker is a state machine with four states:

| State | Meaning |
|---|---|
| CMD_IDLE | No command is pending. |
| CMD_SET | A set-protect command is waiting for its stop. |
| CMD_CLR | A reset command that met the voltage qualification is waiting for its stop. |
| CMD_VOID | A reset command that did not meet the qualification is waiting for its stop. |

Its transitions are checked in this order:

| Condition | Effect |
|---|---|
| `stop_evt` in any state | Go to CMD_IDLE. Commit a set from CMD_SET when `hw_wp` is low, or a clear from CMD_CLR. |
| `rst_req` | Go to CMD_CLR when qualified, otherwise to CMD_VOID. |
| `set_req` | Go to CMD_SET. |
| none of the above | Stay in the current state. |

The voltage qualifier is a saturating counter. It counts clocks while `hv_in` is high and restarts from zero when `hv_in` drops.

Top module: `wp_policy_unit`

## Requirements
- R1: With the flag set and `hw_wp` low, addresses 0x00-0x7F give `wr_allowed`=0 and addresses 0x80-0xFF give `wr_allowed`=1. The decision uses the most significant address bit.
- R2: While `hw_wp` is 1, `wr_allowed` is 0 for every address, whatever the flag holds.
- R3: With the flag clear and `hw_wp` low, `wr_allowed` is 1 for every address.
- R4: A `set_req` strobe followed later by a `stop_evt` strobe sets the flag at the clock edge that samples the stop. The new value shows from that edge on, and the flag does not change before the stop.
- R5: A set-protect command leaves the flag unchanged if `hw_wp` is 1 in the cycle of its stop.
- R6: `prot_ack` is 1 exactly when the flag is clear.
- R7: A reset command clears the flag at its stop only if, in the cycle of `rst_req`, `hv_in` had been 1 on at least QUAL_CYCLES consecutive preceding clock edges. A low cycle on `hv_in` restarts that count.
- R8: A stop that closes an unqualified reset command, or a stop with no command pending, leaves the flag unchanged.
- R9: When `stop_evt` and a request strobe come in the same cycle, the stop closes the pending command and the request is dropped.
- R10: After reset, the flag equals the INIT_FLAG parameter (default 0) and no command is pending.
- R11: A later request replaces a pending one. If `rst_req` and `set_req` arrive in the same cycle, `rst_req` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_wp | input | 1 | Hardware protect pin level; 1 protects everything |
| hv_in | input | 1 | Digital high-voltage-present indication on the protect pin |
| set_req | input | 1 | One-cycle strobe: a set-protect command was received |
| rst_req | input | 1 | One-cycle strobe: a reset-fuse command started |
| stop_evt | input | 1 | One-cycle strobe: stop condition ends the transaction |
| wr_addr | input | ADDR_W | Address of the byte about to be committed |
| wr_allowed | output | 1 | 1 when a write to `wr_addr` may change the array |
| prot_ack | output | 1 | 1 when a protect-register control byte should be acknowledged |

## Verification
`wr_allowed` is combinational in `wr_addr` and `hw_wp`, so it is due in the same cycle that those inputs change. A flag change is due one edge after the stop strobe is sampled, and `prot_ack` follows in the same cycle. The qualifier counts the edges that sample `hv_in` high before the edge that samples `rst_req`. The bench drives inputs 1 ns after a rising edge, updates its behavioural model on the rising edge, and compares both outputs with the model on every falling edge. Its directed checks also sample on falling edges, one cycle after the strobe under test, and they cover the qualification boundary at QUAL_CYCLES-1 and at QUAL_CYCLES consecutive cycles.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_SET  = 2'd1,
        CMD_CLR  = 2'd2,
        CMD_VOID = 2'd3
    } cmd_state_t;

endpackage

// File: rtl/wp_hv_qual.sv
module wp_hv_qual #(
    parameter int QUAL_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hv_in,
    output logic hv_ok
);
    localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Saturating run-length count of consecutive high samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!hv_in) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hv_ok = (cnt_q == CNT_MAX);

endmodule

// File: rtl/wp_cmd_fsm.sv
module wp_cmd_fsm
    import wp_pkg::*;
#(
    parameter bit INIT_FLAG = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_wp,
    input  logic hv_ok,
    input  logic set_req,
    input  logic rst_req,
    input  logic stop_evt,
    output logic flag_q
);
    cmd_state_t state_q, state_d;
    logic       commit_set;
    logic       commit_clr;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: stop closes, then reset request, then set request.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE, CMD_SET, CMD_CLR, CMD_VOID: begin
                if (stop_evt) begin
                    state_d = CMD_IDLE;
                end else if (rst_req) begin
                    state_d = hv_ok ? CMD_CLR : CMD_VOID;
                end else if (set_req) begin
                    state_d = CMD_SET;
                end
            end
            default: state_d = CMD_IDLE;
        endcase
    end

    // Output decode: commit strobes at the closing stop.
    always_comb begin
        commit_set = 1'b0;
        commit_clr = 1'b0;
        unique case (state_q)
            CMD_SET:  commit_set = stop_evt && !hw_wp;
            CMD_CLR:  commit_clr = stop_evt;
            CMD_IDLE: ;
            CMD_VOID: ;
            default:  ;
        endcase
    end

    // Protect flag, standing in for the non-volatile cell.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= INIT_FLAG;
        end else if (commit_clr) begin
            flag_q <= 1'b0;
        end else if (commit_set) begin
            flag_q <= 1'b1;
        end
    end

endmodule

// File: rtl/wp_addr_gate.sv
module wp_addr_gate #(
    parameter int ADDR_W = 8
) (
    input  logic              flag,
    input  logic              hw_wp,
    input  logic [ADDR_W-1:0] addr,
    output logic              allowed
);
    // The lower half of the space is the region the flag covers.
    logic in_low_half;

    assign in_low_half = !addr[ADDR_W-1];
    assign allowed     = !hw_wp && !(flag && in_low_half);

endmodule

// File: rtl/wp_policy_unit.sv
module wp_policy_unit #(
    parameter int ADDR_W      = 8,
    parameter int QUAL_CYCLES = 100,
    parameter bit INIT_FLAG   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_wp,
    input  logic              hv_in,
    input  logic              set_req,
    input  logic              rst_req,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_allowed,
    output logic              prot_ack
);
    logic hv_ok;
    logic flag_q;

    wp_hv_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .hv_in (hv_in),
        .hv_ok (hv_ok)
    );

    wp_cmd_fsm #(.INIT_FLAG(INIT_FLAG)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_wp    (hw_wp),
        .hv_ok    (hv_ok),
        .set_req  (set_req),
        .rst_req  (rst_req),
        .stop_evt (stop_evt),
        .flag_q   (flag_q)
    );

    wp_addr_gate #(.ADDR_W(ADDR_W)) u_gate (
        .flag    (flag_q),
        .hw_wp   (hw_wp),
        .addr    (wr_addr),
        .allowed (wr_allowed)
    );

    assign prot_ack = !flag_q;

endmodule

// File: rtl/wp_policy_chk.sv
module wp_policy_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_wp,
    input logic              hv_in,
    input logic              stop_evt,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_allowed,
    input logic              prot_ack,
    input logic              hv_ok
);
    // R2
    hw_pin_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_wp |-> !wr_allowed);

    // R1
    low_half_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_ack && !wr_addr[ADDR_W-1]) |-> !wr_allowed);

    // R1
    high_half_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_wp && wr_addr[ADDR_W-1]) |-> wr_allowed);

    // R4
    set_only_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_ack) |-> $past(stop_evt && !hw_wp));

    // R7
    clear_only_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_ack) |-> $past(stop_evt));

    // R7
    hv_drop_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hv_in) |-> !hv_ok);

endmodule

bind wp_policy_unit wp_policy_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_wp      (hw_wp),
    .hv_in      (hv_in),
    .stop_evt   (stop_evt),
    .wr_addr    (wr_addr),
    .wr_allowed (wr_allowed),
    .prot_ack   (prot_ack),
    .hv_ok      (hv_ok)
);

// File: tb/sim_wp_policy_unit.sv
`timescale 1ns/1ps
module sim_wp_policy_unit;
    localparam int Q = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_wp = 1'b0;
    logic       hv_in = 1'b0;
    logic       set_req = 1'b0;
    logic       rst_req = 1'b0;
    logic       stop_evt = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic       wr_allowed;
    logic       prot_ack;

    int checks = 0;
    int failures = 0;

    // Reference model state
    bit m_flag;
    int m_pend;   // 0 none, 1 set, 2 good reset, 3 bad reset
    int m_hv;

    always #5 clk = ~clk;

    wp_policy_unit #(.ADDR_W(8), .QUAL_CYCLES(Q), .INIT_FLAG(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .hw_wp(hw_wp), .hv_in(hv_in),
        .set_req(set_req), .rst_req(rst_req), .stop_evt(stop_evt),
        .wr_addr(wr_addr), .wr_allowed(wr_allowed), .prot_ack(prot_ack)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = 1'b0;
            m_pend = 0;
            m_hv   = 0;
        end else begin
            if (stop_evt) begin
                if (m_pend == 1 && !hw_wp) m_flag = 1'b1;
                if (m_pend == 2) m_flag = 1'b0;
                m_pend = 0;
            end else if (rst_req) begin
                m_pend = (m_hv >= Q) ? 2 : 3;
            end else if (set_req) begin
                m_pend = 1;
            end
            if (hv_in) m_hv = m_hv + 1;
            else m_hv = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit exp_allow = !hw_wp && !(m_flag && !wr_addr[7]);
            check(wr_allowed == exp_allow, "R1 per-cycle wr_allowed", wr_allowed, exp_allow);
            check(prot_ack == !m_flag, "R6 per-cycle prot_ack", prot_ack, !m_flag);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic strobe(input bit s, input bit r, input bit p);
        set_req = s; rst_req = r; stop_evt = p;
        step(1);
        set_req = 0; rst_req = 0; stop_evt = 0;
    endtask

    task automatic expect_ack(input bit exp, input string tag);
        @(negedge clk);
        check(prot_ack == exp, tag, prot_ack, exp);
        step(1);
    endtask

    task automatic expect_allow(input logic [7:0] a, input bit exp, input string tag);
        wr_addr = a;
        @(negedge clk);
        check(wr_allowed == exp, tag, wr_allowed, exp);
        step(1);
    endtask

    task automatic hv_run(input int n);
        hv_in = 1;
        step(n);
    endtask

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        expect_ack(1, "R10 reset flag clear");
        // R3
        expect_allow(8'h00, 1, "R3 low addr open");
        expect_allow(8'hFF, 1, "R3 high addr open");
        // R2
        hw_wp = 1;
        expect_allow(8'h90, 0, "R2 hw pin high addr");
        expect_allow(8'h10, 0, "R2 hw pin low addr");
        // R5: set blocked by hw pin at stop
        strobe(1, 0, 0);
        strobe(0, 0, 1);
        expect_ack(1, "R5 set blocked by hw pin");
        hw_wp = 0;
        // R4: set takes effect at stop only
        strobe(1, 0, 0);
        step(3);
        expect_ack(1, "R4 no change before stop");
        strobe(0, 0, 1);
        expect_ack(0, "R4 flag set after stop");
        expect_allow(8'h7F, 0, "R1 0x7F blocked");
        expect_allow(8'h80, 1, "R1 0x80 open");
        expect_allow(8'h00, 0, "R1 0x00 blocked");
        hw_wp = 1;
        expect_allow(8'hC0, 0, "R2 hw pin overrides flag");
        hw_wp = 0;
        // R8: stop with nothing pending
        strobe(0, 0, 1);
        expect_ack(0, "R8 bare stop no effect");
        // R7: one short of the qualification window
        hv_run(Q - 1);
        strobe(0, 1, 0);
        hv_in = 0;
        strobe(0, 0, 1);
        expect_ack(0, "R7 Q-1 cycles not qualified");
        // R7: broken run restarts the count
        hv_run(60);
        hv_in = 0; step(1);
        hv_run(60);
        strobe(0, 1, 0);
        hv_in = 0;
        strobe(0, 0, 1);
        expect_ack(0, "R7 dropped hv restarts count");
        // R7: exactly Q cycles qualifies
        hv_run(Q);
        strobe(0, 1, 0);
        hv_in = 0;
        step(2);
        expect_ack(0, "R7 no clear before stop");
        strobe(0, 0, 1);
        expect_ack(1, "R7 qualified reset clears");
        // R9: stop with simultaneous request drops the request
        strobe(1, 0, 1);
        strobe(0, 0, 1);
        expect_ack(1, "R9 same-cycle set dropped");
        // R11: later set replaces pending unqualified reset
        strobe(0, 1, 0);
        strobe(1, 0, 0);
        strobe(0, 0, 1);
        expect_ack(0, "R11 later set wins");
        // R11: simultaneous reset and set, reset (qualified) wins
        hv_run(Q + 5);
        strobe(1, 1, 0);
        hv_in = 0;
        strobe(0, 0, 1);
        expect_ack(1, "R11 reset wins over set");
        // R8: unqualified reset does not clear
        strobe(1, 0, 0);
        strobe(0, 0, 1);
        strobe(0, 1, 0);
        strobe(0, 0, 1);
        expect_ack(0, "R8 unqualified reset no effect");
        // R10: reset returns the flag to its power-on value
        rst_n = 0;
        step(2);
        rst_n = 1;
        step(1);
        expect_ack(1, "R10 flag back to init");
        step(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule